// File: doc/BRIEF.md
# I2C SCL Clock Waveform Generator

This block times the two halves of the SCL clock for an I2C master. It runs from the system clock. Each half period is built from an 8-bit divisor, scaled by a power-of-two prescaler and padded by a fixed build-time offset. The low phase and the high phase each have their own divisor, so the duty cycle can be uneven. The prescaler exponent and both divisors arrive together in one configuration word. For equal divisors the SCL rate is Fclk / (2 × (div × 2^exp + offset)). Typical targets are 100 kHz, and 400 kHz at most.

While enabled, the block pulls SCL low for one low phase and then releases it. It does not count the high phase until the line actually reads high, so a slave that holds SCL low stretches the clock. A strobe marks the last cycle of each half period so that the byte sequencer can advance. A new configuration word is taken only when a low phase starts, which means a half period already in progress is never shortened. When the block is disabled, SCL is released and the counter is cleared.

Top module: `scl_clkgen`

## Requirements
- R1: With the generator enabled, every low phase drives `scl_pull_low` high for exactly low_div × 2^exp + OFFSET consecutive cycles. low_div is `cfg_word[7:0]` and exp is `cfg_word[18:16]`.
- R2: Without stretching, SCL stays released for exactly high_div × 2^exp + OFFSET cycles between two low phases. high_div is `cfg_word[15:8]`.
- R3: The two divisors act independently, so a configuration with different high and low divisors gives phases of different lengths.
- R4: An exponent field above MAX_CKDIV is treated as MAX_CKDIV, and both divisors are then forced to 255.
- R5: The high-phase count advances only in cycles where `scl_in` is sampled high. `high_done` is never asserted while `scl_in` is low.
- R6: A change to `cfg_word` during a phase has no effect on that phase or on the high phase that follows it. It first applies to the next low phase.
- R7: In the cycle after `gen_en` is sampled low, `scl_pull_low` is 0. While disabled, no strobe is asserted. The first low phase after re-enabling has its full length.
- R8: `low_done` is high only in the last cycle of a low phase, and `high_done` only in the last cycle of a high phase. The two strobes are never high together. After `high_done`, the next cycle pulls SCL low.
- R9: During reset `scl_pull_low`, `low_done` and `high_done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| gen_en | input | 1 | Enables the clock generator |
| cfg_word | input | 19 | [18:16] prescale exponent, [15:8] high divisor, [7:0] low divisor |
| scl_in | input | 1 | Sampled SCL line level, already synchronous to clk |
| scl_pull_low | output | 1 | 1 = drive SCL low, 0 = release |
| low_done | output | 1 | Strobe in the last cycle of a low phase |
| high_done | output | 1 | Strobe in the last cycle of a high phase |

## Verification
The checker treats `scl_in` as a signal that is already synchronous to `clk`. It also takes for granted that the line reads low in every cycle in which the block pulls it. The bench meets both assumptions by modelling the line as the wired-AND of the block's pull and a slave hold signal. Every input, including the configuration word and the slave hold, changes only on falling clock edges. MAX_CKDIV keeps its default of 5, so the 3-bit field can reach the saturating values 6 and 7.

// File: rtl/scl_clkgen_pkg.sv
package scl_clkgen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_t;

  localparam int CFG_W      = 19;
  localparam int DIV_W      = 8;
  localparam int EXP_W      = 3;
  localparam int EXP_LSB    = 16;
  localparam int HDIV_LSB   = 8;
  localparam int LDIV_LSB   = 0;
  localparam logic [DIV_W-1:0] DIV_SAT = 8'd255;
endpackage

// File: rtl/scl_cfg_decode.sv
module scl_cfg_decode
  import scl_clkgen_pkg::*;
#(
  parameter int MAX_CKDIV = 5,
  parameter int OFFSET    = 4,
  parameter int CW        = 13
) (
  input  logic [CFG_W-1:0] cfg_word,
  output logic [CW-1:0]    lo_load,
  output logic [CW-1:0]    hi_load
);
  localparam logic [EXP_W-1:0] EXP_MAX = EXP_W'(MAX_CKDIV);
  localparam logic [CW-1:0]    OFF_M1  = CW'(OFFSET - 1);

  logic [EXP_W-1:0] exp_raw;
  logic             exp_sat;
  logic [EXP_W-1:0] exp_eff;
  logic [DIV_W-1:0] hdiv_eff;
  logic [DIV_W-1:0] ldiv_eff;

  assign exp_raw = cfg_word[EXP_LSB +: EXP_W];

  generate
    if (MAX_CKDIV < (2**EXP_W) - 1) begin : g_sat
      assign exp_sat = (exp_raw > EXP_MAX);
    end else begin : g_nosat
      assign exp_sat = 1'b0;
    end
  endgenerate

  always_comb begin
    exp_eff  = exp_sat ? EXP_MAX : exp_raw;
    hdiv_eff = exp_sat ? DIV_SAT : cfg_word[HDIV_LSB +: DIV_W];
    ldiv_eff = exp_sat ? DIV_SAT : cfg_word[LDIV_LSB +: DIV_W];
    lo_load  = (CW'(ldiv_eff) << exp_eff) + OFF_M1;
    hi_load  = (CW'(hdiv_eff) << exp_eff) + OFF_M1;
  end
endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          step,
  output logic          zero
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | load | step;
    cnt_d  = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (load)
      cnt_d = load_val;
    else if (step)
      cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
  import scl_clkgen_pkg::*;
#(
  parameter int MAX_CKDIV = 5,
  parameter int OFFSET    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_en,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             scl_in,
  output logic             scl_pull_low,
  output logic             low_done,
  output logic             high_done
);
  localparam int CW = $clog2(255 * (2**MAX_CKDIV) + OFFSET + 1);

  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rsync_q <= 2'b00;
    else
      rsync_q <= {rsync_q[0], 1'b1};
  end
  assign core_rst_n = rsync_q[1];

  logic [CW-1:0] new_lo_load;
  logic [CW-1:0] new_hi_load;

  scl_cfg_decode #(
    .MAX_CKDIV (MAX_CKDIV),
    .OFFSET    (OFFSET),
    .CW        (CW)
  ) i_decode (
    .cfg_word (cfg_word),
    .lo_load  (new_lo_load),
    .hi_load  (new_hi_load)
  );

  phase_t        state_q, state_d;
  logic [CW-1:0] hi_len_q;
  logic          hi_len_we;
  logic          t_clr, t_load, t_step, t_zero;
  logic [CW-1:0] t_val;

  scl_phase_timer #(.CW(CW)) i_timer (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .clr      (t_clr),
    .load     (t_load),
    .load_val (t_val),
    .step     (t_step),
    .zero     (t_zero)
  );

  // next-state logic
  always_comb begin
    state_d   = state_q;
    t_clr     = ~gen_en;
    t_load    = 1'b0;
    t_val     = new_lo_load;
    t_step    = 1'b0;
    hi_len_we = 1'b0;
    if (!gen_en) begin
      state_d = PH_IDLE;
    end else begin
      unique case (state_q)
        PH_IDLE: begin
          state_d   = PH_LOW;
          t_load    = 1'b1;
          hi_len_we = 1'b1;
        end
        PH_LOW: begin
          if (t_zero) begin
            state_d = PH_HIGH;
            t_load  = 1'b1;
            t_val   = hi_len_q;
          end else begin
            t_step = 1'b1;
          end
        end
        PH_HIGH: begin
          if (scl_in) begin
            if (t_zero) begin
              state_d   = PH_LOW;
              t_load    = 1'b1;
              hi_len_we = 1'b1;
            end else begin
              t_step = 1'b1;
            end
          end
        end
        default: state_d = PH_IDLE;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)
      state_q <= PH_IDLE;
    else
      state_q <= state_d;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)
      hi_len_q <= '0;
    else if (hi_len_we)
      hi_len_q <= new_hi_load;
  end

  assign scl_pull_low = (state_q == PH_LOW);
  assign low_done     = gen_en & (state_q == PH_LOW) & t_zero;
  assign high_done    = gen_en & (state_q == PH_HIGH) & t_zero & scl_in;
endmodule

// File: rtl/scl_clkgen_chk.sv
module scl_clkgen_chk (
  input logic clk,
  input logic rst_n,
  input logic gen_en,
  input logic scl_in,
  input logic scl_pull_low,
  input logic low_done,
  input logic high_done
);
  assert_strobes_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(low_done && high_done));

  assert_low_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    low_done |=> !low_done);

  assert_high_done_then_pull_R8: assert property (@(posedge clk) disable iff (!rst_n)
    high_done |=> scl_pull_low);

  assert_low_done_then_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    low_done |=> !scl_pull_low);

  assert_no_high_end_stretched_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_in |-> !high_done);

  assert_release_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> !scl_pull_low);

  assert_low_strobe_while_pulled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    low_done |-> scl_pull_low);
endmodule

bind scl_clkgen scl_clkgen_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .gen_en       (gen_en),
  .scl_in       (scl_in),
  .scl_pull_low (scl_pull_low),
  .low_done     (low_done),
  .high_done    (high_done)
);

// File: tb/test_scl_clkgen.sv
module test_scl_clkgen;
  logic        clk;
  logic        rst_n;
  logic        gen_en;
  logic [18:0] cfg_word;
  logic        slave_hold;
  logic        scl_in;
  logic        scl_pull_low;
  logic        low_done;
  logic        high_done;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  // OFFSET = 4, MAX_CKDIV = 5: length = div * 2^exp + 4
  localparam int NV = 7;
  localparam logic [18:0] VCFG [NV] = '{19'h00A0A, 19'h10305, 19'h20001,
                                        19'h50201, 19'h0FF00, 19'h60101, 19'h70909};
  localparam int VLO [NV] = '{14, 14, 8, 36, 4, 8164, 8164};
  localparam int VHI [NV] = '{14, 10, 4, 68, 259, 8164, 8164};

  assign scl_in = !(scl_pull_low | slave_hold);

  scl_clkgen i_scl_clkgen (
    .clk          (clk),
    .rst_n        (rst_n),
    .gen_en       (gen_en),
    .cfg_word     (cfg_word),
    .scl_in       (scl_in),
    .scl_pull_low (scl_pull_low),
    .low_done     (low_done),
    .high_done    (high_done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_low_start();
    int guard = 0;
    while (!scl_pull_low && guard < 100) begin
      @(negedge clk);
      guard++;
    end
  endtask

  // starts on a negedge inside a low phase; ends at the first negedge of the next low phase
  task automatic measure(output int lo, output int hi);
    lo = 0;
    hi = 0;
    while (scl_pull_low && lo < 20000) begin
      lo++;
      @(negedge clk);
    end
    while (!scl_pull_low && hi < 20000) begin
      hi++;
      @(negedge clk);
    end
  endtask

  task automatic restart(input logic [18:0] cfg);
    gen_en = 1'b0;
    repeat (2) @(negedge clk);
    cfg_word = cfg;
    gen_en   = 1'b1;
    @(negedge clk);
    wait_low_start();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int lo, hi, cnt;
    bit bad;
    rst_n      = 1'b0;
    gen_en     = 1'b0;
    cfg_word   = 19'h00A0A;
    slave_hold = 1'b0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check({scl_pull_low, low_done, high_done} == 3'b000, "R9 reset outputs",
          int'({scl_pull_low, low_done, high_done}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7: disabled keeps the line released
    bad = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (scl_pull_low || low_done || high_done) bad = 1'b1;
      @(negedge clk);
    end
    check(!bad, "R7 idle while disabled", int'(bad), 0);

    // table walk: R1 low length, R2 high length, R3 asymmetric, R4 saturation
    for (int v = 0; v < NV; v++) begin
      restart(VCFG[v]);
      measure(lo, hi);
      check(lo == VLO[v], (v >= 5) ? "R4 saturated low length" : "R1 low length", lo, VLO[v]);
      check(hi == VHI[v], (v >= 5) ? "R4 saturated high length" :
                          (v == 1) ? "R3 asymmetric high length" : "R2 high length", hi, VHI[v]);
    end

    // R6: a config change mid-phase applies from the next low phase
    restart(19'h00A0A);
    cfg_word = 19'h00305;
    measure(lo, hi);
    check(lo == 14, "R6 current low kept", lo, 14);
    check(hi == 14, "R6 current high kept", hi, 14);
    measure(lo, hi);
    check(lo == 9, "R6 next low uses new word", lo, 9);
    check(hi == 7, "R6 next high uses new word", hi, 7);

    // R5: slave stretching of the high phase
    restart(19'h00A0A);
    cnt = 0;
    while (!low_done && cnt < 100) begin
      @(negedge clk);
      cnt++;
    end
    check(low_done == 1'b1, "R8 low strobe in last low cycle", int'(low_done), 1);
    slave_hold = 1'b1;
    cnt = 0;
    bad = 1'b0;
    while (cnt < 1000) begin
      @(negedge clk);
      if (scl_pull_low) break;
      if (high_done && slave_hold) bad = 1'b1;
      cnt++;
      if (cnt == 6) slave_hold = 1'b0;
    end
    check(cnt == 19, "R5 stretched high length", cnt, 19);
    check(!bad, "R5 no high strobe while held", int'(bad), 0);

    // R8: high strobe sits in the last released cycle
    measure(lo, hi);
    cnt = 0;
    while (!high_done && cnt < 100) begin
      @(negedge clk);
      cnt++;
    end
    @(negedge clk);
    check(scl_pull_low == 1'b1, "R8 pull follows high strobe", int'(scl_pull_low), 1);

    // R7: disable mid low phase, then full low phase on re-enable
    repeat (5) @(negedge clk);
    gen_en = 1'b0;
    @(negedge clk);
    check(scl_pull_low == 1'b0, "R7 released after disable", int'(scl_pull_low), 0);
    bad = 1'b0;
    for (int i = 0; i < 10; i++) begin
      if (scl_pull_low || low_done || high_done) bad = 1'b1;
      @(negedge clk);
    end
    check(!bad, "R7 quiet while disabled", int'(bad), 0);
    gen_en = 1'b1;
    @(negedge clk);
    wait_low_start();
    measure(lo, hi);
    check(lo == 14, "R7 full low after re-enable", lo, 14);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule